// File: doc/BRIEF.md
# Temperature Threshold Alarm Comparator

This block watches a stream of signed temperature samples and raises an alarm when a sample crosses a programmable limit. Samples and the limit are 16-bit two's complement numbers in steps of 1/64 degree Celsius. A two-bit direction select chooses whether a sample at or above the limit counts as a hit, or a sample at or below it. Only the two defined directions can produce a hit; the other two codes are reserved and never do.

Each accepted sample updates a live status bit that shows whether that sample hit the limit. A hit also sets a sticky alarm flag, which stays set until software pulses a clear strobe. The interrupt line is the sticky flag gated by an enable bit, so software can mask the alarm without losing the flag. The flag is only ever set by a fresh sample, never by a change of the limit or the direction between samples.

Top module: `thrcmp_alarm`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cmp_live`, `alarm_flag` and `alarm_irq` are 0 after that edge.
- R2: With `cmp_mode` = 1 (at-or-above), a sample accepted at an edge with `smp_vld` high makes `cmp_live` equal to (sample >= limit) after that edge.
- R3: With `cmp_mode` = 0 (at-or-below), an accepted sample makes `cmp_live` equal to (sample <= limit) after that edge.
- R4: With `cmp_mode` = 2 or 3, an accepted sample drives `cmp_live` to 0 and never sets `alarm_flag`.
- R5: Sample and limit are compared as signed two's complement numbers (0xFFFF is below 0x0001).
- R6: A sample equal to the limit is a hit in both mode 0 and mode 1.
- R7: When `smp_vld` is low, `cmp_live` and `alarm_flag` keep their values, whatever the limit and mode do.
- R8: An accepted sample that hits sets `alarm_flag` after that edge; the flag stays set across later samples that miss.
- R9: A `flag_clr` pulse with no hitting sample in the same cycle drives `alarm_flag` to 0 after that edge.
- R10: If a hitting sample and `flag_clr` arrive in the same cycle, `alarm_flag` is 1 after that edge.
- R11: `alarm_irq` is high exactly when `alarm_flag` and `irq_en` are both high, with no clock delay from `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe; the sample is compared on this cycle only |
| smp_val | input | 16 | Signed temperature sample, 1/64 degree units |
| thr_val | input | 16 | Signed limit, 1/64 degree units |
| cmp_mode | input | 2 | Direction: 0 at-or-below, 1 at-or-above, 2 and 3 reserved |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Pulse that clears the sticky flag |
| cmp_live | output | 1 | Hit result of the most recent accepted sample |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Flag gated by the enable |

## Verification
The hardest case to reach is a hitting sample and a clear pulse landing in the same cycle, since software normally clears between samples; the bench drives both strobes on one clock to show the set is kept. Signed ordering is exercised with a negative sample against a small positive limit, a pair that an unsigned comparator would rank the other way. The hold behaviour is reached by retuning the limit and direction while no strobe is present and confirming neither output moves.

// File: rtl/thrcmp_pkg.sv
package thrcmp_pkg;

    localparam int SAMPLE_W = 16;
    localparam int MODE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_AT_OR_BELOW = 2'd0,
        MODE_AT_OR_ABOVE = 2'd1,
        MODE_RESERVED_A  = 2'd2,
        MODE_RESERVED_B  = 2'd3
    } cmp_mode_e;

    typedef struct packed {
        logic live;
        logic flag;
    } alarm_state_t;

endpackage

// File: rtl/thrcmp_eval.sv
module thrcmp_eval
    import thrcmp_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic signed [W-1:0] sample,
    input  logic signed [W-1:0] limit,
    input  cmp_mode_e           mode,
    output logic                hit
);

    logic ge_res;
    logic le_res;

    assign ge_res = (sample >= limit);
    assign le_res = (sample <= limit);

    always_comb begin
        case (mode)
            MODE_AT_OR_ABOVE: hit = ge_res;
            MODE_AT_OR_BELOW: hit = le_res;
            default:          hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/thrcmp_latch.sv
module thrcmp_latch
    import thrcmp_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         vld,
    input  logic         hit,
    input  logic         clr,
    output alarm_state_t st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (vld) begin
                st.live <= hit;
            end
            if (vld && hit) begin
                st.flag <= 1'b1;
            end else if (clr) begin
                st.flag <= 1'b0;
            end
        end
    end

    assert_status_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(st.live));

    assert_flag_no_spont_R7: assert property (@(posedge clk) disable iff (rst)
        (!vld && !st.flag) |=> !st.flag);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (vld && hit) |=> st.flag);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr && !(vld && hit)) |=> !st.flag);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (clr && vld && hit) |=> st.flag);

endmodule

// File: rtl/thrcmp_alarm.sv
module thrcmp_alarm
    import thrcmp_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_val,
    input  logic [DATA_W-1:0] thr_val,
    input  logic [MODE_W-1:0] cmp_mode,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              cmp_live,
    output logic              alarm_flag,
    output logic              alarm_irq
);

    logic         hit_w;
    alarm_state_t state_q;

    thrcmp_eval #(.W(DATA_W)) u_eval (
        .sample (smp_val),
        .limit  (thr_val),
        .mode   (cmp_mode_e'(cmp_mode)),
        .hit    (hit_w)
    );

    thrcmp_latch u_latch (
        .clk (clk),
        .rst (rst),
        .vld (smp_vld),
        .hit (hit_w),
        .clr (flag_clr),
        .st  (state_q)
    );

    assign cmp_live   = state_q.live;
    assign alarm_flag = state_q.flag;
    assign alarm_irq  = state_q.flag & irq_en;

    assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && cmp_mode[1]) |=> !cmp_live);

    assert_reserved_noflag_R4: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && cmp_mode[1] && !alarm_flag) |=> !alarm_flag);

    assert_ge_signed_R2: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && cmp_mode == 2'd1 && $signed(smp_val) >= $signed(thr_val)) |=> alarm_flag);

    always_comb begin
        assert_irq_gate_R11: assert (!alarm_irq || (irq_en && alarm_flag));
    end

endmodule

// File: tb/thrcmp_alarm_tb_top.sv
`timescale 1ns/1ps
module thrcmp_alarm_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        smp_vld;
    logic [15:0] smp_val;
    logic [15:0] thr_val;
    logic [1:0]  cmp_mode;
    logic        irq_en;
    logic        flag_clr;
    logic        cmp_live;
    logic        alarm_flag;
    logic        alarm_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    thrcmp_alarm dut_i (
        .clk        (clk),
        .rst        (rst),
        .smp_vld    (smp_vld),
        .smp_val    (smp_val),
        .thr_val    (thr_val),
        .cmp_mode   (cmp_mode),
        .irq_en     (irq_en),
        .flag_clr   (flag_clr),
        .cmp_live   (cmp_live),
        .alarm_flag (alarm_flag),
        .alarm_irq  (alarm_irq)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one sample at a falling edge; results are visible at the next falling edge.
    task automatic put_sample(input logic [15:0] v, input logic [15:0] t,
                              input logic [1:0] m, input logic clr);
        smp_val  = v;
        thr_val  = t;
        cmp_mode = m;
        smp_vld  = 1'b1;
        flag_clr = clr;
        @(negedge clk);
        smp_vld  = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic drop_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(cmp_live,   1'b0, "R1 live in reset");
        chk(alarm_flag, 1'b0, "R1 flag in reset");
        chk(alarm_irq,  1'b0, "R1 irq in reset");
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_above();
        put_sample(16'd3300, 16'd3200, 2'd1, 1'b0);
        chk(cmp_live,   1'b1, "R2 above hit live");
        chk(alarm_flag, 1'b1, "R8 above hit flag");
        drop_flag();
        put_sample(16'd3100, 16'd3200, 2'd1, 1'b0);
        chk(cmp_live,   1'b0, "R2 above miss live");
        chk(alarm_flag, 1'b0, "R2 above miss flag");
    endtask

    task automatic t_below();
        put_sample(16'd100, 16'd640, 2'd0, 1'b0);
        chk(cmp_live,   1'b1, "R3 below hit live");
        chk(alarm_flag, 1'b1, "R3 below hit flag");
        drop_flag();
        put_sample(16'd700, 16'd640, 2'd0, 1'b0);
        chk(cmp_live,   1'b0, "R3 below miss live");
    endtask

    task automatic t_equal();
        put_sample(16'd1234, 16'd1234, 2'd1, 1'b0);
        chk(cmp_live, 1'b1, "R6 equal in mode 1");
        put_sample(16'd1234, 16'd1234, 2'd0, 1'b0);
        chk(cmp_live, 1'b1, "R6 equal in mode 0");
        drop_flag();
    endtask

    task automatic t_signed();
        put_sample(16'hFFFF, 16'h0001, 2'd1, 1'b0);
        chk(cmp_live,   1'b0, "R5 -1 >= 1 false");
        chk(alarm_flag, 1'b0, "R5 no flag on signed miss");
        put_sample(16'hFFFF, 16'h0001, 2'd0, 1'b0);
        chk(cmp_live, 1'b1, "R5 -1 <= 1 true");
        drop_flag();
        put_sample(16'hF600, 16'hF800, 2'd0, 1'b0);
        chk(cmp_live, 1'b1, "R5 -40C <= -32C true");
        drop_flag();
    endtask

    task automatic t_reserved();
        put_sample(16'd500, 16'd100, 2'd1, 1'b0);
        drop_flag();
        chk(cmp_live, 1'b1, "R4 setup live high");
        put_sample(16'd500, 16'd100, 2'd2, 1'b0);
        chk(cmp_live,   1'b0, "R4 mode 2 live low");
        chk(alarm_flag, 1'b0, "R4 mode 2 no flag");
        put_sample(16'd100, 16'd100, 2'd3, 1'b0);
        chk(cmp_live,   1'b0, "R4 mode 3 live low");
        chk(alarm_flag, 1'b0, "R4 mode 3 no flag");
    endtask

    task automatic t_hold_sticky();
        put_sample(16'd900, 16'd800, 2'd1, 1'b0);
        thr_val  = 16'd2000;
        cmp_mode = 2'd0;
        repeat (3) @(negedge clk);
        chk(cmp_live,   1'b1, "R7 live held without strobe");
        chk(alarm_flag, 1'b1, "R7 flag held without strobe");
        drop_flag();
        thr_val  = 16'd0;
        cmp_mode = 2'd1;
        repeat (3) @(negedge clk);
        chk(alarm_flag, 1'b0, "R7 no flag from limit change");
        put_sample(16'd900, 16'd800, 2'd1, 1'b0);
        put_sample(16'd10, 16'd800, 2'd1, 1'b0);
        chk(cmp_live,   1'b0, "R8 live follows miss");
        chk(alarm_flag, 1'b1, "R8 flag stays after miss");
        drop_flag();
        chk(alarm_flag, 1'b0, "R9 clear pulse");
    endtask

    task automatic t_set_wins();
        put_sample(16'd900, 16'd800, 2'd1, 1'b1);
        chk(alarm_flag, 1'b1, "R10 set beats clear");
        put_sample(16'd10, 16'd800, 2'd1, 1'b1);
        chk(alarm_flag, 1'b0, "R9 clear with missing sample");
    endtask

    task automatic t_irq();
        irq_en = 1'b0;
        put_sample(16'd900, 16'd800, 2'd1, 1'b0);
        chk(alarm_irq, 1'b0, "R11 masked irq");
        irq_en = 1'b1;
        #1;
        chk(alarm_irq, 1'b1, "R11 irq on enable");
        @(negedge clk);
        drop_flag();
        chk(alarm_irq, 1'b0, "R11 irq drops with flag");
        irq_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; smp_vld = 1'b0; smp_val = '0; thr_val = '0;
        cmp_mode = '0; irq_en = 1'b0; flag_clr = 1'b0;
        @(negedge clk);
        t_reset();
        t_above();
        t_below();
        t_equal();
        t_signed();
        t_reserved();
        t_hold_sticky();
        t_set_wins();
        t_irq();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule